// File: doc/BRIEF.md
# Bulk OUT Transmit Packet Buffer

This block holds outgoing bulk packets for a single host-side OUT endpoint. Software or a DMA engine pushes packet bytes one at a time through a byte port. It then marks the packet complete. The block stores each complete packet in one of two packet slots, together with its byte count. A configuration bit sets how many slots may be occupied at once: one slot in single mode, two slots in double mode.

The transmit engine always sees the oldest complete packet. It pulls bytes one per read strobe. When the exchange ends, it reports one of two outcomes. An acknowledge frees the slot. A retry rewinds the same packet to its first byte so that it can be sent again.

The block also provides three outputs: a DMA request while a slot is free, a not-empty flag, and a sticky overrun flag. A flush command drops the oldest packet, one packet per command.

Top module: `bulk_tx_pktbuf`

## Requirements
- R1: After reset the following hold: `not_empty` = 0, `tx_valid` = 0, `overrun` = 0, and `dma_req` equals `cfg_dma_en`.
- R2: A committed packet of N accepted bytes is presented with `tx_len` = N. The bytes appear on `tx_rd_data` in the order they were written, and each `rd_en` cycle advances one byte. `tx_last` is 1 exactly while the final byte is presented.
- R3: A slot accepts at most L bytes, where L = min(`cfg_maxp`, MAX_PKT). Bytes written beyond L are dropped, and the packet length stays L.
- R4: With `cfg_dbl_en` = 0, one packet fills the buffer. A commit while a packet is held is ignored, and the held packet is unchanged.
- R5: With `cfg_dbl_en` = 1, two packets can be held at once, and they are presented in the order they were committed.
- R6: A `tx_ack` while `tx_valid` is 1 frees the presented slot. The next queued packet, if there is one, is presented from the first byte in the following cycle.
- R7: A `tx_nak` rewinds the presented packet to its first byte. The packet stays queued with the same length and data.
- R8: `dma_req` is 1 exactly when `cfg_dma_en` is 1 and a slot is free under the current mode.
- R9: `not_empty` is 1 while at least one packet is held.
- R10: Each `flush` pulse discards only the oldest held packet. In double mode, two pulses empty a full buffer.
- R11: A commit while no slot is free sets `overrun`. The flag stays set until reset.
- R12: Bytes written while no slot is free are dropped. They never appear in a later packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dbl_en | input | 1 | 1 = two packet slots, 0 = one slot |
| cfg_dma_en | input | 1 | Enables the DMA request output |
| cfg_maxp | input | LEN_W | Maximum packet size in bytes |
| wr_valid | input | 1 | Byte write strobe |
| wr_data | input | DATA_W | Byte to store |
| wr_commit | input | 1 | Marks the packet being written as complete |
| rd_en | input | 1 | Advances to the next byte of the presented packet |
| tx_ack | input | 1 | Packet accepted; frees its slot |
| tx_nak | input | 1 | Packet must be resent; rewinds to byte 0 |
| flush | input | 1 | Discards the oldest held packet |
| tx_valid | output | 1 | A packet is presented |
| tx_len | output | LEN_W | Byte count of the presented packet |
| tx_rd_data | output | DATA_W | Current byte of the presented packet |
| tx_last | output | 1 | Current byte is the final one |
| not_empty | output | 1 | At least one packet is held |
| dma_req | output | 1 | A slot is free and DMA is enabled |
| overrun | output | 1 | Sticky: a commit was refused |

## Verification
The bench targets the points where a packet buffer tends to go wrong: a second commit in single mode, bytes streamed in while the buffer is full, an oversize packet, and a retry in the middle of a packet.

Each mistake has a visible symptom. A design that ignores the mode bit accepts the second packet and leaves `overrun` clear. A design that keeps bytes written while full leaks them into the next packet's length. A design that does not clamp at the maximum size reports a length above it. A design that fails to rewind on retry resumes mid-packet instead of at the first byte.

Ordering and flush are checked with two queued packets. A design that frees the wrong slot, or drops both packets on one flush, presents the wrong length or the wrong data.
// File: rtl/txpb_pkg.sv
package txpb_pkg;
  typedef logic slot_t;
  typedef enum logic [1:0] {
    RD_HOLD    = 2'd0,
    RD_STEP    = 2'd1,
    RD_REWIND  = 2'd2,
    RD_RELEASE = 2'd3
  } rd_evt_e;
endpackage
// File: rtl/txpb_store.sv
module txpb_store #(
  parameter int DATA_W = 8,
  parameter int MAX_PKT = 64,
  localparam int ADDR_W = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic                clk,
  input  logic                we,
  input  txpb_pkg::slot_t     wslot,
  input  logic [ADDR_W-1:0]   waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  txpb_pkg::slot_t     rslot,
  input  logic [ADDR_W-1:0]   raddr,
  output logic [DATA_W-1:0]   rdata
);
  logic [DATA_W-1:0] slot_q [2];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [DATA_W-1:0] mem [MAX_PKT];
    logic slot_we;
    assign slot_we = we && (wslot == 1'(s));
    always_ff @(posedge clk) begin
      if (slot_we) mem[waddr] <= wdata;
    end
    assign slot_q[s] = mem[raddr];
  end

  assign rdata = slot_q[rslot];
endmodule
// File: rtl/txpb_fill.sv
module txpb_fill #(
  parameter int MAX_PKT = 64,
  localparam int LEN_W = $clog2(MAX_PKT + 1),
  localparam int ADDR_W = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_commit,
  input  logic              room,
  input  logic [LEN_W-1:0]  lim,
  output logic              byte_we,
  output logic [ADDR_W-1:0] byte_addr,
  output txpb_pkg::slot_t   wr_ptr,
  output logic              commit_ok,
  output logic [LEN_W-1:0]  commit_len,
  output logic              overrun
);
  logic [LEN_W-1:0] wr_cnt, wr_cnt_d;
  txpb_pkg::slot_t  wr_ptr_d;
  logic             ovr_d;

  always_comb begin
    byte_we    = wr_valid && room && (wr_cnt < lim);
    byte_addr  = wr_cnt[ADDR_W-1:0];
    commit_ok  = wr_commit && room;
    commit_len = wr_cnt + LEN_W'(byte_we);
    wr_cnt_d   = commit_ok ? '0 : commit_len;
    wr_ptr_d   = commit_ok ? ~wr_ptr : wr_ptr;
    ovr_d      = overrun || (wr_commit && !room);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_cnt  <= '0;
      wr_ptr  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      wr_cnt  <= wr_cnt_d;
      wr_ptr  <= wr_ptr_d;
      overrun <= ovr_d;
    end
  end
endmodule
// File: rtl/txpb_drain.sv
module txpb_drain #(
  parameter int MAX_PKT = 64,
  localparam int LEN_W = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              tx_ack,
  input  logic              tx_nak,
  input  logic              flush,
  input  logic              head_vld,
  input  logic [LEN_W-1:0]  head_len,
  output txpb_pkg::slot_t   rd_ptr,
  output logic [LEN_W-1:0]  rd_off,
  output logic              release_o
);
  import txpb_pkg::*;
  rd_evt_e          evt;
  logic [LEN_W-1:0] rd_off_d;
  slot_t            rd_ptr_d;

  always_comb begin
    if (head_vld && (tx_ack || flush))           evt = RD_RELEASE;
    else if (tx_nak)                             evt = RD_REWIND;
    else if (rd_en && head_vld && rd_off < head_len) evt = RD_STEP;
    else                                         evt = RD_HOLD;
    release_o = (evt == RD_RELEASE);
    rd_ptr_d  = release_o ? ~rd_ptr : rd_ptr;
    case (evt)
      RD_RELEASE, RD_REWIND: rd_off_d = '0;
      RD_STEP:               rd_off_d = rd_off + 1'b1;
      default:               rd_off_d = rd_off;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= 1'b0;
      rd_off <= '0;
    end else begin
      rd_ptr <= rd_ptr_d;
      rd_off <= rd_off_d;
    end
  end
endmodule
// File: rtl/bulk_tx_pktbuf.sv
module bulk_tx_pktbuf #(
  parameter int DATA_W = 8,
  parameter int MAX_PKT = 64,
  localparam int LEN_W = $clog2(MAX_PKT + 1),
  localparam int ADDR_W = (MAX_PKT > 1) ? $clog2(MAX_PKT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dbl_en,
  input  logic              cfg_dma_en,
  input  logic [LEN_W-1:0]  cfg_maxp,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_commit,
  input  logic              rd_en,
  input  logic              tx_ack,
  input  logic              tx_nak,
  input  logic              flush,
  output logic              tx_valid,
  output logic [LEN_W-1:0]  tx_len,
  output logic [DATA_W-1:0] tx_rd_data,
  output logic              tx_last,
  output logic              not_empty,
  output logic              dma_req,
  output logic              overrun
);
  import txpb_pkg::*;

  logic [1:0]       slot_vld;
  logic [LEN_W-1:0] slot_len [2];
  logic             room;
  logic [LEN_W-1:0] lim;
  logic             byte_we, commit_ok, release_w;
  logic [ADDR_W-1:0] byte_addr;
  logic [LEN_W-1:0] commit_len, rd_off;
  slot_t            wr_ptr, rd_ptr;
  logic             head_vld;
  logic [LEN_W-1:0] head_len;

  always_comb begin
    lim      = (cfg_maxp > LEN_W'(MAX_PKT)) ? LEN_W'(MAX_PKT) : cfg_maxp;
    room     = cfg_dbl_en ? !slot_vld[wr_ptr] : (slot_vld == 2'b00);
    head_vld = slot_vld[rd_ptr];
    head_len = slot_len[rd_ptr];
  end

  txpb_fill #(.MAX_PKT(MAX_PKT)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_commit(wr_commit),
    .room(room), .lim(lim), .byte_we(byte_we), .byte_addr(byte_addr),
    .wr_ptr(wr_ptr), .commit_ok(commit_ok), .commit_len(commit_len),
    .overrun(overrun)
  );

  txpb_drain #(.MAX_PKT(MAX_PKT)) u_drain (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .tx_ack(tx_ack),
    .tx_nak(tx_nak), .flush(flush), .head_vld(head_vld),
    .head_len(head_len), .rd_ptr(rd_ptr), .rd_off(rd_off),
    .release_o(release_w)
  );

  txpb_store #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT)) u_store (
    .clk(clk), .we(byte_we), .wslot(wr_ptr), .waddr(byte_addr),
    .wdata(wr_data), .rslot(rd_ptr), .raddr(rd_off[ADDR_W-1:0]),
    .rdata(tx_rd_data)
  );

  for (genvar s = 0; s < 2; s++) begin : g_state
    logic             set_s, clr_s, vld_d;
    logic [LEN_W-1:0] len_d;
    always_comb begin
      set_s = commit_ok && (wr_ptr == 1'(s));
      clr_s = release_w && (rd_ptr == 1'(s));
      vld_d = set_s ? 1'b1 : (clr_s ? 1'b0 : slot_vld[s]);
      len_d = set_s ? commit_len : slot_len[s];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_vld[s] <= 1'b0;
        slot_len[s] <= '0;
      end else begin
        slot_vld[s] <= vld_d;
        slot_len[s] <= len_d;
      end
    end
  end

  always_comb begin
    tx_valid  = head_vld;
    tx_len    = head_len;
    tx_last   = head_vld && (head_len != '0) && (rd_off == head_len - 1'b1);
    not_empty = |slot_vld;
    dma_req   = cfg_dma_en && room;
  end
endmodule

module bulk_tx_pktbuf_chk #(
  parameter int MAX_PKT = 64,
  localparam int LEN_W = $clog2(MAX_PKT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_dbl_en,
  input logic             cfg_dma_en,
  input logic             wr_commit,
  input logic             tx_ack,
  input logic             tx_nak,
  input logic             flush,
  input logic             tx_valid,
  input logic [LEN_W-1:0] tx_len,
  input logic             not_empty,
  input logic             dma_req,
  input logic             overrun,
  input logic [1:0]       slot_vld,
  input logic [LEN_W-1:0] rd_off
);
  // R8
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dma_en |-> !dma_req);
  // R9
  status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> not_empty);
  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R4
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dbl_en && slot_vld != 2'b00 && wr_commit && !tx_ack && !flush)
      |=> slot_vld == $past(slot_vld));
  // R7
  retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_nak && !tx_ack && !flush) |=> rd_off == '0);
  // R3
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_len <= LEN_W'(MAX_PKT));
  // R2
  off_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> rd_off <= tx_len);
  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ack && tx_valid && $countones(slot_vld) == 1 && !wr_commit)
      |=> !not_empty);
endmodule

bind bulk_tx_pktbuf bulk_tx_pktbuf_chk #(.MAX_PKT(MAX_PKT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dbl_en(cfg_dbl_en), .cfg_dma_en(cfg_dma_en),
  .wr_commit(wr_commit), .tx_ack(tx_ack), .tx_nak(tx_nak), .flush(flush),
  .tx_valid(tx_valid), .tx_len(tx_len), .not_empty(not_empty),
  .dma_req(dma_req), .overrun(overrun), .slot_vld(slot_vld), .rd_off(rd_off)
);
// File: tb/bulk_tx_pktbuf_test.sv
`timescale 1ns/1ps
module bulk_tx_pktbuf_test;
  localparam int DATA_W = 8;
  localparam int MAX_PKT = 64;
  localparam int LEN_W = $clog2(MAX_PKT + 1);

  logic clk, rst_n, cfg_dbl_en, cfg_dma_en;
  logic [LEN_W-1:0] cfg_maxp;
  logic wr_valid, wr_commit, rd_en, tx_ack, tx_nak, flush;
  logic [DATA_W-1:0] wr_data, tx_rd_data;
  logic tx_valid, tx_last, not_empty, dma_req, overrun;
  logic [LEN_W-1:0] tx_len;

  int checks = 0, failures = 0;
  bit done = 0;
  int exp_len_q[$];
  byte unsigned exp_byte_q[$];

  bulk_tx_pktbuf #(.DATA_W(DATA_W), .MAX_PKT(MAX_PKT)) uut (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // driver: writes a packet and pushes expected contents to the scoreboard
  task automatic send(input int n, input int seed, input bit accept);
    int lim;
    lim = (int'(cfg_maxp) > MAX_PKT) ? MAX_PKT : int'(cfg_maxp);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1; wr_data = 8'(seed + i);
      @(negedge clk);
    end
    wr_valid = 0;
    wr_commit = 1;
    @(negedge clk);
    wr_commit = 0;
    if (accept) begin
      int k;
      k = (n < lim) ? n : lim;
      exp_len_q.push_back(k);
      for (int i = 0; i < k; i++) exp_byte_q.push_back(8'(seed + i));
    end
  endtask

  task automatic pop_expected();
    int k;
    k = exp_len_q.pop_front();
    for (int i = 0; i < k; i++) void'(exp_byte_q.pop_front());
  endtask

  // monitor: compares the presented packet against the scoreboard head
  // action 0 = ack, 1 = nak after upto bytes, 2 = leave
  task automatic drain(input string tag, input int upto, input int action);
    int k;
    chk(tx_valid === 1'b1, {tag, " valid"}, tx_valid, 1);
    k = exp_len_q[0];
    chk(int'(tx_len) == k, {tag, " len"}, tx_len, k);
    if (upto < 0 || upto > k) upto = k;
    for (int i = 0; i < upto; i++) begin
      chk(tx_rd_data == exp_byte_q[i], {tag, " data"}, tx_rd_data, exp_byte_q[i]);
      chk(tx_last == (i == k - 1), {tag, " last"}, tx_last, (i == k - 1));
      rd_en = 1;
      @(negedge clk);
      rd_en = 0;
    end
    if (action == 0) begin
      tx_ack = 1; @(negedge clk); tx_ack = 0;
      pop_expected();
    end else if (action == 1) begin
      tx_nak = 1; @(negedge clk); tx_nak = 0;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++; failures++;
    $display("FAIL watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_dbl_en = 0; cfg_dma_en = 1; cfg_maxp = 7'd16;
    wr_valid = 0; wr_data = 0; wr_commit = 0; rd_en = 0;
    tx_ack = 0; tx_nak = 0; flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(not_empty == 0, "R1 not_empty", not_empty, 0);
    chk(tx_valid == 0, "R1 tx_valid", tx_valid, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    chk(dma_req == 1, "R1 dma_req", dma_req, 1);

    // single mode: one packet fills the buffer
    send(5, 8'h10, 1);
    chk(not_empty == 1, "R9 not_empty", not_empty, 1);
    chk(dma_req == 0, "R8 dma_req full", dma_req, 0);
    send(3, 8'h80, 0);        // R4 / R12: refused, bytes dropped
    chk(overrun == 1, "R11 overrun set", overrun, 1);
    drain("R4 R2 held pkt", -1, 0);
    chk(not_empty == 0, "R6 empty after ack", not_empty, 0);
    chk(dma_req == 1, "R8 dma_req free", dma_req, 1);
    send(3, 8'h40, 1);        // R12 fresh packet has only new bytes
    drain("R12 next pkt", -1, 0);

    // R3 clamp at cfg_maxp
    send(20, 8'h20, 1);
    drain("R3 clamped", -1, 0);

    // R7 retry mid packet
    send(6, 8'h60, 1);
    drain("R7 partial", 3, 1);
    drain("R7 resend", -1, 0);

    // R5 double mode ordering
    cfg_dbl_en = 1;
    @(negedge clk);
    send(4, 8'hA0, 1);
    chk(dma_req == 1, "R8 one slot free", dma_req, 1);
    send(7, 8'hB0, 1);
    chk(dma_req == 0, "R8 both full", dma_req, 0);
    send(2, 8'hC0, 0);
    drain("R5 first", -1, 0);
    chk(not_empty == 1, "R6 second held", not_empty, 1);
    drain("R5 second", -1, 0);
    chk(not_empty == 0, "R9 drained", not_empty, 0);

    // R10 flush one at a time
    send(9, 8'h30, 1);
    send(2, 8'h50, 1);
    flush = 1; @(negedge clk); flush = 0;
    pop_expected();
    chk(not_empty == 1, "R10 one left", not_empty, 1);
    drain("R10 survivor", -1, 2);
    send(3, 8'h70, 1);
    flush = 1; @(negedge clk); flush = 0;
    pop_expected();
    flush = 1; @(negedge clk); flush = 0;
    pop_expected();
    chk(not_empty == 0, "R10 two flushes", not_empty, 0);

    // R8 dma gate
    cfg_dma_en = 0;
    @(negedge clk);
    chk(dma_req == 0, "R8 dma disabled", dma_req, 0);
    chk(overrun == 1, "R11 still set", overrun, 1);
    finish_run();
  end
endmodule